// File: doc/BRIEF.md
# Flash Erase and Program Sequencer

This block is the host side of a serial flash link. It runs one complete write-type operation each time it is started: a 4 KB erase, a 32 KB erase, a whole-array erase, a page program or a status register write. Each operation is sent as three parts. First a write-enable frame. Then the command frame. Then status-read frames, repeated until the device reports ready. Every part has its own chip-select low period. The serial clock comes from the system clock through a configurable divider, in SPI mode 0.

The caller gives an operation code, a 24-bit address and a length. For a page program, the caller also supplies the data stream one byte at a time when the block asks for it. The block returns a one-cycle `done` pulse. An `error` flag is raised in the same cycle when the request was refused or the device stayed busy for too long. Requests that could never succeed are refused before the bus is touched. Between frames, chip select stays high for a minimum number of system clocks.

Top module: `flash_op_seq`

## Requirements
- R1: While reset is held and after it, `spi_cs_n` is 1, `spi_sck` is 0, and `busy`, `done`, `error` and `data_req` are 0.
- R2: A valid operation first sends a one-byte frame 06h. Every byte goes out MSB first in SPI mode 0: SCK idles low, MOSI is stable around each rising SCK edge, and the input is sampled on that edge.
- R3: The second frame starts with the opcode chosen by `op`: 0 → D7h, 1 → D8h, 2 → C7h, 3 → 02h, 4 → 01h. Code 2 sends the opcode alone.
- R4: Codes 0, 1 and 3 follow the opcode with three address bytes, bits 23:16 first, then 15:8, then 7:0. Address bits 17 and up are sent as 0. Code 0 also clears bits 11:0, and code 1 also clears bits 14:0.
- R5: Code 3 follows the address with exactly `len` data bytes, in stream order. There is one `data_req` cycle per byte, and `wr_data` is taken in that same cycle.
- R6: Code 4 sends exactly two bytes, 01h and then `addr[7:0]`.
- R7: If `len` is 0, or if `addr[7:0] + len` exceeds 256 for code 3, or if `op` is 5, 6 or 7, then `done` and `error` are 1 in the cycle after `start`. Chip select stays high and `data_req` stays 0.
- R8: Chip select rises only after a whole byte has been sent. Between frames it stays high for at least `CS_GAP` system clocks.
- R9: After the command frame, the block sends frames of 05h followed by 00h, reading the status byte during the second byte. A read with bit 0 = 1 means busy. The first read with bit 0 = 0 ends the operation: `done` pulses for one cycle, with `error` = 0, in the cycle in which chip select rises.
- R10: If `POLL_LIMIT` status reads in a row all report busy, the block stops after the last of them and gives `done` together with `error` = 1.
- R11: A `start` while `busy` is 1 is ignored and does not change the frames of the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only while idle) |
| op | input | 3 | Operation code, encoding as in R3 |
| addr | input | 24 | Target address; bits 7:0 carry the value for a status write |
| len | input | 9 | Page program byte count, 1 to 256 |
| wr_data | input | 8 | Program data byte, taken while `data_req` is 1 |
| data_req | output | 1 | The block takes `wr_data` in this cycle |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| error | output | 1 | With `done`: request refused or poll timeout |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Each result has a fixed cycle in which it is due, and the bench samples there on falling clock edges.

- **Refused request:** `done` and `error` are due on the first rising edge after `start`. The bench samples them at the next falling edge, then watches 40 more cycles for any chip-select or `data_req` activity.
- **Accepted operation:** `done` is due on the same edge that raises chip select after the final status byte. The bench records `spi_cs_n` at every falling edge while it waits, and requires it to have been low one sample before `done` and high at `done`. One sample later, `done` must have dropped.
- **Data stream:** each data byte is due in the cycle its `data_req` is high. The bench advances its stream index on that edge.
- **Frame contents:** the bench's SPI device model captures bytes on rising SCK and compares them against frames built from the requirements.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [2:0] {
        OP_ERASE_4K  = 3'd0,
        OP_ERASE_32K = 3'd1,
        OP_ERASE_ALL = 3'd2,
        OP_PROGRAM   = 3'd3,
        OP_STAT_WR   = 3'd4
    } op_e;

    localparam logic [7:0] CMD_WR_EN     = 8'h06;
    localparam logic [7:0] CMD_STAT_RD   = 8'h05;
    localparam logic [7:0] CMD_ERASE_4K  = 8'hD7;
    localparam logic [7:0] CMD_ERASE_32K = 8'hD8;
    localparam logic [7:0] CMD_ERASE_ALL = 8'hC7;
    localparam logic [7:0] CMD_PROGRAM   = 8'h02;
    localparam logic [7:0] CMD_STAT_WR   = 8'h01;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GAP,
        ST_LAUNCH,
        ST_XFER
    } seq_state_e;

    typedef enum logic [1:0] {
        FR_WR_EN,
        FR_CMD,
        FR_POLL
    } frame_e;

endpackage

// File: rtl/flash_req_check.sv
module flash_req_check
    import flash_seq_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    parameter int ADDR_BITS  = 17,
    parameter int SSEC_BYTES = 4096,
    parameter int SEC_BYTES  = 32768,
    parameter int LW         = 9,
    parameter int IW         = 9
) (
    input  logic [2:0]    op,
    input  logic [23:0]   addr,
    input  logic [LW-1:0] len,
    output logic          ok,
    output logic [7:0]    opcode,
    output logic [23:0]   addr_o,
    output logic [IW-1:0] last_idx,
    output logic          is_prog
);
    localparam int PB = $clog2(PAGE_BYTES);
    localparam logic [23:0] AMASK     = 24'((64'd1 << ADDR_BITS) - 64'd1);
    localparam logic [23:0] SSEC_MASK = ~24'(SSEC_BYTES - 1);
    localparam logic [23:0] SEC_MASK  = ~24'(SEC_BYTES - 1);
    localparam logic [LW:0] PAGE_END  = (LW+1)'(PAGE_BYTES);

    logic [LW:0] end_off;
    assign end_off = (LW+1)'(addr[PB-1:0]) + (LW+1)'(len);

    always_comb begin
        ok       = 1'b0;
        opcode   = 8'h00;
        addr_o   = addr & AMASK;
        last_idx = '0;
        is_prog  = 1'b0;
        case (op)
            OP_ERASE_4K: begin
                ok       = 1'b1;
                opcode   = CMD_ERASE_4K;
                addr_o   = addr & AMASK & SSEC_MASK;
                last_idx = IW'(3);
            end
            OP_ERASE_32K: begin
                ok       = 1'b1;
                opcode   = CMD_ERASE_32K;
                addr_o   = addr & AMASK & SEC_MASK;
                last_idx = IW'(3);
            end
            OP_ERASE_ALL: begin
                ok       = 1'b1;
                opcode   = CMD_ERASE_ALL;
                last_idx = '0;
            end
            OP_PROGRAM: begin
                ok       = (len != '0) && (end_off <= PAGE_END);
                opcode   = CMD_PROGRAM;
                last_idx = IW'(len) + IW'(3);
                is_prog  = 1'b1;
            end
            OP_STAT_WR: begin
                ok       = 1'b1;
                opcode   = CMD_STAT_WR;
                last_idx = IW'(1);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/flash_spi_shifter.sv
module flash_spi_shifter #(
    parameter int CLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx
);
    localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);

    typedef struct packed {
        logic          act;
        logic          sck;
        logic          done;
        logic [2:0]    bitn;
        logic [DW-1:0] div;
        logic [7:0]    sh;
        logic [7:0]    rx;
    } shf_t;

    shf_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (!r_q.act) begin
            if (go) begin
                r_d.act  = 1'b1;
                r_d.sck  = 1'b0;
                r_d.sh   = tx;
                r_d.bitn = 3'd0;
                r_d.div  = '0;
            end
        end else if (r_q.div != DIV_LAST) begin
            r_d.div = r_q.div + 1'b1;
        end else begin
            r_d.div = '0;
            if (!r_q.sck) begin
                r_d.sck = 1'b1;
                r_d.rx  = {r_q.rx[6:0], miso};
            end else begin
                r_d.sck = 1'b0;
                if (r_q.bitn == 3'd7) begin
                    r_d.act  = 1'b0;
                    r_d.done = 1'b1;
                end else begin
                    r_d.bitn = r_q.bitn + 3'd1;
                    r_d.sh   = {r_q.sh[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sck  = r_q.sck;
    assign mosi = r_q.sh[7];
    assign busy = r_q.act;
    assign done = r_q.done;
    assign rx   = r_q.rx;

    assert_go_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !r_q.act);
    assert_done_after_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> (!r_q.sck && $past(r_q.sck)));
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int CS_GAP     = 4,
    parameter int POLL_LIMIT = 1000,
    parameter int IW         = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          req_ok,
    input  logic [7:0]    req_opc,
    input  logic [23:0]   req_addr,
    input  logic [7:0]    req_sval,
    input  logic [IW-1:0] req_last,
    input  logic          req_prog,
    input  logic [7:0]    wr_data,
    input  logic          eng_busy,
    input  logic          eng_done,
    input  logic [7:0]    eng_rx,
    input  logic          eng_sck,
    output logic          eng_go,
    output logic [7:0]    eng_tx,
    output logic          data_req,
    output logic          busy,
    output logic          done,
    output logic          error,
    output logic          cs_n
);
    localparam int GW = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;
    localparam int PW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
    localparam logic [GW-1:0] GAP_LAST  = GW'(CS_GAP - 1);
    localparam logic [PW-1:0] POLL_LAST = PW'(POLL_LIMIT - 1);
    localparam logic [GW:0]   HI_MIN    = (GW+1)'(CS_GAP);

    typedef struct packed {
        seq_state_e    st;
        frame_e        fr;
        logic [IW-1:0] idx;
        logic [IW-1:0] last;
        logic [IW-1:0] last_cmd;
        logic [GW-1:0] gap;
        logic [PW-1:0] polls;
        logic [7:0]    opc;
        logic [23:0]   addr;
        logic [7:0]    sval;
        logic          prog;
        logic          cs_n;
        logic          done;
        logic          err;
    } ctrl_t;

    ctrl_t r_q, r_d;
    logic [7:0] byte_sel;

    always_comb begin
        byte_sel = 8'h00;
        case (r_q.fr)
            FR_WR_EN: byte_sel = CMD_WR_EN;
            FR_POLL:  byte_sel = (r_q.idx == '0) ? CMD_STAT_RD : 8'h00;
            default: begin
                case (r_q.idx)
                    IW'(0):  byte_sel = r_q.opc;
                    IW'(1):  byte_sel = (r_q.opc == CMD_STAT_WR) ? r_q.sval : r_q.addr[23:16];
                    IW'(2):  byte_sel = r_q.addr[15:8];
                    IW'(3):  byte_sel = r_q.addr[7:0];
                    default: byte_sel = wr_data;
                endcase
            end
        endcase
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        eng_go   = 1'b0;
        eng_tx   = 8'h00;
        data_req = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (!req_ok) begin
                        r_d.done = 1'b1;
                        r_d.err  = 1'b1;
                    end else begin
                        r_d.opc      = req_opc;
                        r_d.addr     = req_addr;
                        r_d.sval     = req_sval;
                        r_d.prog     = req_prog;
                        r_d.last_cmd = req_last;
                        r_d.fr       = FR_WR_EN;
                        r_d.idx      = '0;
                        r_d.last     = '0;
                        r_d.gap      = '0;
                        r_d.polls    = '0;
                        r_d.st       = ST_GAP;
                    end
                end
            end
            ST_GAP: begin
                if (r_q.gap == GAP_LAST) begin
                    r_d.gap  = '0;
                    r_d.cs_n = 1'b0;
                    r_d.st   = ST_LAUNCH;
                end else begin
                    r_d.gap = r_q.gap + 1'b1;
                end
            end
            ST_LAUNCH: begin
                eng_go   = 1'b1;
                eng_tx   = byte_sel;
                data_req = r_q.prog && (r_q.fr == FR_CMD) && (r_q.idx > IW'(3));
                r_d.st   = ST_XFER;
            end
            default: begin
                if (eng_done) begin
                    if (r_q.idx == r_q.last) begin
                        r_d.cs_n = 1'b1;
                        r_d.idx  = '0;
                        r_d.st   = ST_GAP;
                        case (r_q.fr)
                            FR_WR_EN: begin
                                r_d.fr   = FR_CMD;
                                r_d.last = r_q.last_cmd;
                            end
                            FR_CMD: begin
                                r_d.fr   = FR_POLL;
                                r_d.last = IW'(1);
                            end
                            default: begin
                                if (!eng_rx[0]) begin
                                    r_d.done = 1'b1;
                                    r_d.st   = ST_IDLE;
                                end else if (r_q.polls == POLL_LAST) begin
                                    r_d.done = 1'b1;
                                    r_d.err  = 1'b1;
                                    r_d.st   = ST_IDLE;
                                end else begin
                                    r_d.polls = r_q.polls + 1'b1;
                                end
                            end
                        endcase
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                        r_d.st  = ST_LAUNCH;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.cs_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy  = (r_q.st != ST_IDLE);
    assign done  = r_q.done;
    assign error = r_q.err;
    assign cs_n  = r_q.cs_n;

    logic [GW:0] hi_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          hi_cnt <= '0;
        else if (!r_q.cs_n)  hi_cnt <= '0;
        else if (hi_cnt < HI_MIN) hi_cnt <= hi_cnt + 1'b1;
    end

    assert_cs_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.cs_n) |-> (hi_cnt >= HI_MIN));
    assert_cs_rise_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.cs_n) |-> !eng_busy);
    assert_mode0_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.cs_n) |-> !eng_sck);
    assert_bad_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && start && !req_ok) |=> (r_q.done && r_q.err && r_q.cs_n));
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |=> !r_q.done);
    assert_req_in_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        data_req |-> (!r_q.cs_n && r_q.fr == FR_CMD));
endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq #(
    parameter int CLK_DIV    = 2,
    parameter int CS_GAP     = 4,
    parameter int POLL_LIMIT = 1000,
    parameter int PAGE_BYTES = 256,
    parameter int ADDR_BITS  = 17,
    parameter int SSEC_BYTES = 4096,
    parameter int SEC_BYTES  = 32768,
    localparam int LW = $clog2(PAGE_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op,
    input  logic [23:0]   addr,
    input  logic [LW-1:0] len,
    input  logic [7:0]    wr_data,
    output logic          data_req,
    output logic          busy,
    output logic          done,
    output logic          error,
    output logic          spi_cs_n,
    output logic          spi_sck,
    output logic          spi_mosi,
    input  logic          spi_miso
);
    localparam int IW = $clog2(PAGE_BYTES + 5);

    logic          req_ok, req_prog;
    logic [7:0]    req_opc;
    logic [23:0]   req_addr;
    logic [IW-1:0] req_last;
    logic          eng_go, eng_busy, eng_done, eng_sck;
    logic [7:0]    eng_tx, eng_rx;

    flash_req_check #(
        .PAGE_BYTES(PAGE_BYTES), .ADDR_BITS(ADDR_BITS),
        .SSEC_BYTES(SSEC_BYTES), .SEC_BYTES(SEC_BYTES),
        .LW(LW), .IW(IW)
    ) u_check (
        .op(op), .addr(addr), .len(len),
        .ok(req_ok), .opcode(req_opc), .addr_o(req_addr),
        .last_idx(req_last), .is_prog(req_prog)
    );

    flash_seq_ctrl #(
        .CS_GAP(CS_GAP), .POLL_LIMIT(POLL_LIMIT), .IW(IW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .req_ok(req_ok), .req_opc(req_opc), .req_addr(req_addr),
        .req_sval(addr[7:0]), .req_last(req_last), .req_prog(req_prog),
        .wr_data(wr_data),
        .eng_busy(eng_busy), .eng_done(eng_done), .eng_rx(eng_rx), .eng_sck(eng_sck),
        .eng_go(eng_go), .eng_tx(eng_tx),
        .data_req(data_req), .busy(busy), .done(done), .error(error),
        .cs_n(spi_cs_n)
    );

    flash_spi_shifter #(
        .CLK_DIV(CLK_DIV)
    ) u_shift (
        .clk(clk), .rst_n(rst_n), .go(eng_go), .tx(eng_tx), .miso(spi_miso),
        .sck(eng_sck), .mosi(spi_mosi), .busy(eng_busy), .done(eng_done), .rx(eng_rx)
    );

    assign spi_sck = eng_sck;
endmodule

// File: tb/tb_flash_op_seq.sv
module tb_flash_op_seq;
    localparam int CLK_DIV    = 1;
    localparam int CS_GAP     = 3;
    localparam int POLL_LIMIT = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] op = 3'd0;
    logic [23:0] addr = 24'd0;
    logic [8:0] len = 9'd0;
    logic [7:0] wr_data;
    logic data_req, busy, done, error, spi_cs_n, spi_sck, spi_mosi, spi_miso;

    flash_op_seq #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP), .POLL_LIMIT(POLL_LIMIT)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr), .len(len),
        .wr_data(wr_data), .data_req(data_req), .busy(busy), .done(done), .error(error),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int errors = 0, checks = 0, cyc = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int k);
        return 8'(k * 29 + 7) ^ 8'hA5;
    endfunction

    int didx = 0, dreq_cnt = 0;
    assign wr_data = pat(didx);
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (data_req) begin
            didx     <= didx + 1;
            dreq_cnt <= dreq_cnt + 1;
        end
    end

    // SPI device model
    int rcnt = 0, nf = 0, nb = 0, poll_seen = 0, busy_polls = 0;
    int misalign = 0, min_gap = 1000, hi_cnt = 0, cs_falls = 0;
    int fstart [0:63];
    int flen [0:63];
    logic [7:0] blog [0:2047];
    logic [7:0] shr = 8'h00;
    logic [7:0] stat;
    assign stat = (poll_seen < busy_polls) ? 8'h01 : 8'hFE;
    assign spi_miso = (rcnt >= 8 && rcnt < 16) ? stat[15 - rcnt] : 1'b0;

    always @(posedge clk) begin
        if (spi_cs_n === 1'b1) hi_cnt = hi_cnt + 1;
        else hi_cnt = 0;
    end
    always @(negedge spi_cs_n) begin
        rcnt = 0;
        cs_falls++;
        if (nf > 0 && hi_cnt < min_gap) min_gap = hi_cnt;
        if (nf < 64) fstart[nf] = nb;
    end
    always @(posedge spi_sck) begin
        if (spi_cs_n === 1'b0) begin
            shr = {shr[6:0], spi_mosi};
            rcnt++;
            if (rcnt % 8 == 0 && nb < 2048) begin
                blog[nb] = shr;
                nb++;
            end
        end
    end
    always @(posedge spi_cs_n) begin
        if (rcnt % 8 != 0) misalign++;
        if (nf < 64) begin
            flen[nf] = nb - fstart[nf];
            if (flen[nf] > 0 && blog[fstart[nf]] == 8'h05) poll_seen++;
        end
        nf++;
    end

    always @(posedge clk) begin
        if (cyc == 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=<190000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    logic [7:0] ex [0:2047];
    int exs [0:63];
    int exl [0:63];

    task automatic run_op(input logic [2:0] o, input logic [23:0] a, input logic [8:0] l,
                          input int nbusy, input bit poke, input string tag);
        bit v, exp_err, prev;
        int p, ne, np, w;
        logic [23:0] am;
        v = (o <= 3'd4) && (o != 3'd3 || (l != 9'd0 && int'(a[7:0]) + int'(l) <= 256));
        exp_err = (nbusy >= POLL_LIMIT);
        // expected frames
        exs[0] = 0; exl[0] = 1; ex[0] = 8'h06; p = 1;
        exs[1] = p;
        case (o)
            3'd0: ex[p] = 8'hD7;
            3'd1: ex[p] = 8'hD8;
            3'd2: ex[p] = 8'hC7;
            3'd3: ex[p] = 8'h02;
            default: ex[p] = 8'h01;
        endcase
        p++;
        am = a & 24'h01FFFF;
        if (o == 3'd0) am = am & ~24'h000FFF;
        if (o == 3'd1) am = am & ~24'h007FFF;
        if (o == 3'd0 || o == 3'd1 || o == 3'd3) begin
            ex[p] = am[23:16]; ex[p+1] = am[15:8]; ex[p+2] = am[7:0]; p += 3;
        end
        if (o == 3'd3) for (int k = 0; k < int'(l); k++) begin ex[p] = pat(k); p++; end
        if (o == 3'd4) begin ex[p] = a[7:0]; p++; end
        exl[1] = p - exs[1];
        np = exp_err ? POLL_LIMIT : nbusy + 1;
        for (int f = 0; f < np; f++) begin
            exs[2+f] = p; exl[2+f] = 2; ex[p] = 8'h05; ex[p+1] = 8'h00; p += 2;
        end
        ne = 2 + np;

        @(negedge clk);
        nf = 0; nb = 0; poll_seen = 0; busy_polls = nbusy; misalign = 0;
        min_gap = 1000; cs_falls = 0; dreq_cnt = 0; didx = 0;
        op = o; addr = a; len = l; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (!v) begin
            check(done === 1'b1 && error === 1'b1, {"R7 refusal flags ", tag}, {done, error}, 3);
            repeat (40) @(negedge clk);
            check(cs_falls == 0 && dreq_cnt == 0, {"R7 no bus activity ", tag},
                  cs_falls + dreq_cnt, 0);
            return;
        end
        w = 0;
        prev = spi_cs_n;
        while (done !== 1'b1 && w < 60000) begin
            prev = spi_cs_n;
            @(negedge clk);
            w++;
            if (poke && w == 40) begin op = 3'd2; start = 1'b1; end
            else start = 1'b0;
        end
        start = 1'b0;
        check(w < 60000, {"R9 done reached ", tag}, w, 0);
        check(error === exp_err, {exp_err ? "R10 timeout error " : "R9 no error ", tag},
              error, exp_err);
        check(spi_cs_n === 1'b1 && prev == 1'b0, {"R9 done on CS rise ", tag},
              {prev, spi_cs_n}, 1);
        @(negedge clk);
        check(done === 1'b0, {"R9 done one cycle ", tag}, done, 0);
        check(nf == ne, {"R2 R9 frame count ", tag}, nf, ne);
        for (int f = 0; f < ne && f < nf && f < 64; f++) begin
            int bad = -1;
            if (flen[f] != exl[f]) bad = 9999;
            else for (int b = 0; b < exl[f]; b++)
                if (bad < 0 && blog[fstart[f] + b] !== ex[exs[f] + b]) bad = b;
            if (f == 0)
                check(bad < 0, {"R2 enable frame ", tag}, flen[f], exl[f]);
            else if (f == 1)
                check(bad < 0, {"R3 R4 R6 command frame ", tag},
                      (bad >= 0 && bad < 9999) ? int'(blog[fstart[f] + bad]) : flen[f],
                      (bad >= 0 && bad < 9999) ? int'(ex[exs[f] + bad]) : exl[f]);
            else
                check(bad < 0, {"R9 poll frame ", tag}, flen[f], exl[f]);
        end
        check(dreq_cnt == ((o == 3'd3) ? int'(l) : 0), {"R5 data request count ", tag},
              dreq_cnt, (o == 3'd3) ? int'(l) : 0);
        check(misalign == 0, {"R8 byte boundary ", tag}, misalign, 0);
        check(min_gap >= CS_GAP, {"R8 CS gap ", tag}, min_gap, CS_GAP);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R1 bus idle in reset", {spi_cs_n, spi_sck}, 2);
        check(busy === 1'b0 && done === 1'b0 && error === 1'b0 && data_req === 1'b0,
              "R1 flags in reset", {busy, done, error, data_req}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(spi_cs_n === 1'b1 && busy === 1'b0 && done === 1'b0, "R1 after reset",
              {spi_cs_n, busy, done}, 4);

        run_op(3'd0, 24'hFE9ABC, 9'd0, 0, 1'b0, "4K erase");
        run_op(3'd1, 24'h13F0F0, 9'd0, 1, 1'b0, "32K erase");
        run_op(3'd2, 24'h000000, 9'd0, 2, 1'b1, "R11 chip erase with start while busy");
        run_op(3'd4, 24'hABCD5A, 9'd0, 3, 1'b0, "R6 status write");
        run_op(3'd3, 24'h012300, 9'd4, 0, 1'b0, "R5 program");

        for (int oi = 0; oi < 4; oi++) begin
            logic [7:0] off;
            case (oi)
                0: off = 8'h00;
                1: off = 8'h80;
                2: off = 8'hF8;
                default: off = 8'hFF;
            endcase
            for (int ln = 0; ln <= 9; ln++)
                run_op(3'd3, {8'h00, 8'h1C, off}, 9'(ln), 0, 1'b0, "R5 R7 program sweep");
            run_op(3'd3, {8'h01, 8'h5A, off}, 9'(256 - int'(off)), 1, 1'b0, "R5 program to page end");
            run_op(3'd3, {8'h01, 8'h5A, off}, 9'(257 - int'(off)), 0, 1'b0, "R7 page crossing");
        end

        for (int o = 5; o < 8; o++)
            run_op(3'(o), 24'h001000, 9'd1, 0, 1'b0, "R7 unknown op");

        run_op(3'd0, 24'h00F123, 9'd0, 10, 1'b0, "R10 poll timeout");
        run_op(3'd4, 24'h00003C, 9'd0, POLL_LIMIT - 1, 1'b0, "R9 ready on last poll");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule